// File: doc/BRIEF.md
# Pattern Checker with Link Hysteresis

This block sits behind a serial receiver's deserializer. It takes one parallel word per valid cycle, predicts every bit of that word from a local pattern reference, and flags the word as bad if any bit differs. It supports four pseudo-random sequences and two clock-like square-wave sequences. The pattern is chosen by a select input that is independent of whatever drives the far-end transmitter.

A link flag with symmetric hysteresis summarises whether the stream is being followed. While the flag is low, the reference rebuilds itself from the received bits, so it locks onto any phase of the stream without help. While the flag is high, the reference runs on its own, so a corrupted bit is counted once and is not spread into later words. Two saturating statistics counters track the words seen and the words in error. Software can zero them at run time without touching the link state.

Top module: `prbs_link_checker`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `link_up` is 0 and both counters are 0; the pattern history starts all-zero.
- R2: Each rising edge with `rx_valid` high adds one to `word_count`. A cycle with `rx_valid` low changes neither counter, nor `link_up`, nor the pattern history, whatever `rx_data` carries.
- R3: A valid word in which one or more bits differ from the prediction adds exactly one to `error_count`, on the same edge that counts the word.
- R4: While `link_up` is 0, it rises on the edge that samples the fifth consecutive valid word without a mismatch. A bad word restarts that run.
- R5: While `link_up` is 1, it falls on the edge that samples the fifth consecutive bad valid word. A good word restarts that run.
- R6: While `link_up` is 0, the history takes the received bits, so any phase of the selected sequence is followed once enough bits have arrived.
- R7: While `link_up` is 1, the history takes the predicted bits, so a single flipped bit costs exactly one error word.
- R8: Bits arrive MSB first. With b[n] the n-th bit of the stream, the `pat_sel` codes select these rules:
  - 0: b[n]=b[n-6]^b[n-7]
  - 1: b[n]=b[n-14]^b[n-15]
  - 2: b[n]=b[n-18]^b[n-23]
  - 3, 6 and 7: b[n]=b[n-28]^b[n-31]
  - 4: b[n]=~b[n-1] (alternating)
  - 5: b[n]=~b[n-10] (ten ones, ten zeros)
- R9: `stat_clr` high zeroes both counters on that edge. It takes priority over a valid word arriving in the same cycle, and it leaves `link_up` unchanged.
- R10: Each counter stops at its all-ones value (CNT_W bits, 48 by default) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_sel | input | 3 | Expected pattern code (see R8) |
| rx_valid | input | 1 | Marks `rx_data` as a word to be checked |
| rx_data | input | DATA_W | Received word, first bit in the MSB |
| stat_clr | input | 1 | Zeroes both statistics counters |
| link_up | output | 1 | Hysteresis-filtered lock flag |
| word_count | output | CNT_W | Saturating count of valid words |
| error_count | output | CNT_W | Saturating count of valid words with a mismatch |

## Verification
Every result is registered. The link flag and both counters reflect a word on the rising edge that samples it, and the history that word leaves behind governs only the next valid word. The bench therefore drives inputs at the falling edge, advances a behavioural bit-queue model right after the rising edge, and compares all three outputs at the following falling edge on every cycle. Targeted sequences place bad words just before the fifth of a run and single-bit flips in free-running mode. The counters are shrunk to 10 bits so that saturation is reached within a short run.

// File: rtl/prbs_chk_pkg.sv
// Shared definitions for the pattern checker: pattern codes and the
// per-pattern recurrence rule (two delays, optional second tap, inversion).
// Assumes a 31-bit history is enough for every supported rule.
package prbs_chk_pkg;

    localparam int HIST_W = 31;

    typedef enum logic [2:0] {
        PAT_P7   = 3'd0,
        PAT_P15  = 3'd1,
        PAT_P23  = 3'd2,
        PAT_P31  = 3'd3,
        PAT_ALT  = 3'd4,
        PAT_SQ10 = 3'd5
    } pat_e;

    typedef struct packed {
        logic [4:0] tap_a;   // delay of first tap, 1..31
        logic [4:0] tap_b;   // delay of second tap
        logic       use_b;   // second tap participates
        logic       invert;  // complement the prediction
    } rule_t;

    // Map a pattern code onto its recurrence; unused codes fall back to 31-bit.
    function automatic rule_t pattern_rule(input logic [2:0] code);
        rule_t r;
        case (code)
            PAT_P7:   r = '{tap_a: 5'd6,  tap_b: 5'd7,  use_b: 1'b1, invert: 1'b0};
            PAT_P15:  r = '{tap_a: 5'd14, tap_b: 5'd15, use_b: 1'b1, invert: 1'b0};
            PAT_P23:  r = '{tap_a: 5'd18, tap_b: 5'd23, use_b: 1'b1, invert: 1'b0};
            PAT_ALT:  r = '{tap_a: 5'd1,  tap_b: 5'd1,  use_b: 1'b0, invert: 1'b1};
            PAT_SQ10: r = '{tap_a: 5'd10, tap_b: 5'd10, use_b: 1'b0, invert: 1'b1};
            default:  r = '{tap_a: 5'd28, tap_b: 5'd31, use_b: 1'b1, invert: 1'b0};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/prbs_word_predictor.sv
// Combinational word predictor. Walks the word first bit (MSB) to last,
// predicting each bit from the recurrence over the history plus the bits
// already placed in this word. The bit placed back into the chain is the
// received one when follow_rx is high (self-synchronising) or the predicted
// one otherwise (free-running). Assumes DATA_W >= 2.
module prbs_word_predictor
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [HIST_W-1:0] hist,       // bit 0 = most recent bit
    input  rule_t             rule,
    input  logic              follow_rx,
    input  logic [DATA_W-1:0] rx_word,
    output logic [DATA_W-1:0] exp_word,
    output logic [HIST_W-1:0] hist_next,
    output logic              word_bad
);
    localparam int SEQ_W  = HIST_W + DATA_W;
    localparam int SIDX_W = $clog2(SEQ_W);
    localparam int DIDX_W = $clog2(DATA_W);

    logic [SEQ_W-1:0]  seq;      // oldest bit at index 0
    logic [DATA_W-1:0] rx_rev;   // index 0 = first received bit
    logic [DATA_W-1:0] exp_rev;
    logic [HIST_W-1:0] hist_rev;

    assign rx_rev   = {<<{rx_word}};
    assign hist_rev = {<<{hist}};

    // Unrolled bit-serial recurrence over the whole word.
    always_comb begin
        seq     = '0;
        exp_rev = '0;
        seq[HIST_W-1:0] = hist_rev;
        for (int i = 0; i < DATA_W; i++) begin
            logic pred;
            pred = seq[SIDX_W'(HIST_W + i - int'(rule.tap_a))]
                 ^ (rule.use_b & seq[SIDX_W'(HIST_W + i - int'(rule.tap_b))])
                 ^ rule.invert;
            exp_rev[DIDX_W'(i)] = pred;
            seq[SIDX_W'(HIST_W + i)] = follow_rx ? rx_rev[DIDX_W'(i)] : pred;
        end
    end

    assign exp_word  = {<<{exp_rev}};
    assign hist_next = {<<{seq[SEQ_W-1 -: HIST_W]}};
    assign word_bad  = |(exp_word ^ rx_word);

endmodule

// File: rtl/prbs_link_tracker.sv
// Link hysteresis. One run counter counts consecutive words that argue
// against the current state (good words while down, bad words while up).
// Reaching RUN_LEN flips the state and restarts the run. Assumes RUN_LEN >= 2.
module prbs_link_tracker #(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic word_bad,
    output logic link_up
);
    localparam int RUN_W = $clog2(RUN_LEN);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);

    logic [RUN_W-1:0] run_q;
    logic             opposing;

    assign opposing = link_up ? word_bad : ~word_bad;

    // Advance or restart the opposing run; flip state at the run's end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= '0;
            link_up <= 1'b0;
        end else if (valid) begin
            if (!opposing) begin
                run_q <= '0;
            end else if (run_q == RUN_LAST) begin
                run_q   <= '0;
                link_up <= ~link_up;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/prbs_sat_counter.sv
// Saturating event counter with a synchronous clear that wins over increment.
module prbs_sat_counter #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value
);
    // Clear, else count up until all ones.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
        end else if (inc && !(&value)) begin
            value <= value + 1'b1;
        end
    end

endmodule

// File: rtl/prbs_link_checker.sv
// Top of the pattern checker. Holds the pattern history, predicts each valid
// word, feeds the mismatch flag to the hysteresis tracker and the two
// statistics counters. Assumes rx_data is word-aligned, first bit in the MSB.
module prbs_link_checker
    import prbs_chk_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 48,
    parameter int RUN_LEN = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        pat_sel,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              stat_clr,
    output logic              link_up,
    output logic [CNT_W-1:0]  word_count,
    output logic [CNT_W-1:0]  error_count
);
    localparam int N_CNT = 2;

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_next;
    logic [DATA_W-1:0] exp_word;
    logic              word_bad;
    rule_t             cur_rule;
    logic [N_CNT-1:0]  cnt_inc;
    logic [CNT_W-1:0]  cnt_val [N_CNT];

    assign cur_rule = pattern_rule(pat_sel);

    prbs_word_predictor #(.DATA_W(DATA_W)) u_pred (
        .hist      (hist_q),
        .rule      (cur_rule),
        .follow_rx (~link_up),
        .rx_word   (rx_data),
        .exp_word  (exp_word),
        .hist_next (hist_next),
        .word_bad  (word_bad)
    );

    // Keep the history of the bit chain; only valid words move it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (rx_valid) begin
            hist_q <= hist_next;
        end
    end

    prbs_link_tracker #(.RUN_LEN(RUN_LEN)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (rx_valid),
        .word_bad (word_bad),
        .link_up  (link_up)
    );

    // Index 0 counts words, index 1 counts bad words.
    assign cnt_inc = {rx_valid & word_bad, rx_valid};

    for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
        prbs_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (stat_clr),
            .inc   (cnt_inc[g]),
            .value (cnt_val[g])
        );
    end

    assign word_count  = cnt_val[0];
    assign error_count = cnt_val[1];

endmodule

// File: rtl/prbs_link_checker_sva.sv
// Port-level properties of the pattern checker, bound onto the top module.
module prbs_link_checker_sva #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             stat_clr,
    input logic             link_up,
    input logic [CNT_W-1:0] word_count,
    input logic [CNT_W-1:0] error_count
);
    // R1: a reset cycle leaves the outputs idle
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!link_up && word_count == '0 && error_count == '0));

    // R2: an idle cycle moves nothing
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !stat_clr) |=>
            ($stable(word_count) && $stable(error_count) && $stable(link_up)));

    // R2: a valid word adds one below saturation
    p_word_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !stat_clr && word_count != '1) |=>
            (word_count == $past(word_count) + CNT_W'(1)));

    // R3: bad words are a subset of words
    p_err_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        error_count <= word_count);

    // R4: link only rises on a sampled word
    p_link_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up) |-> $past(rx_valid));

    // R5: link only falls on a sampled word
    p_link_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(link_up) |-> $past(rx_valid));

    // R9: clear zeroes both counters and leaves link alone
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_clr |=> (word_count == '0 && error_count == '0 && $stable(link_up)));

    // R10: all-ones holds
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (word_count == '1 && !stat_clr) |=> word_count == '1);

endmodule

bind prbs_link_checker prbs_link_checker_sva #(.CNT_W(CNT_W)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .stat_clr    (stat_clr),
    .link_up     (link_up),
    .word_count  (word_count),
    .error_count (error_count)
);

// File: tb/prbs_link_checker_tb.sv
`timescale 1ns/1ps
module prbs_link_checker_tb;
    localparam int DW  = 16;
    localparam int CW  = 10;
    localparam longint CAP = (longint'(1) << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    pat_sel = 3'd0;
    logic          rx_valid = 1'b0;
    logic [DW-1:0] rx_data = '0;
    logic          stat_clr = 1'b0;
    logic          link_up;
    logic [CW-1:0] word_count;
    logic [CW-1:0] error_count;

    always #2.5 clk = ~clk;

    prbs_link_checker #(.DATA_W(DW), .CNT_W(CW), .RUN_LEN(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel), .rx_valid(rx_valid),
        .rx_data(rx_data), .stat_clr(stat_clr), .link_up(link_up),
        .word_count(word_count), .error_count(error_count)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    bit     m_hist[$];
    bit     m_link;
    int     m_good, m_badrun;
    longint m_words, m_errs;
    // transmitter state
    bit     g_hist[$];

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Recurrence parameters per pattern code (R8).
    task automatic taps(input logic [2:0] c, output int a, output int b, output bit useb, output bit inv);
        useb = 1; inv = 0; b = 0;
        case (c)
            3'd0: begin a = 6;  b = 7;  end
            3'd1: begin a = 14; b = 15; end
            3'd2: begin a = 18; b = 23; end
            3'd4: begin a = 1;  useb = 0; inv = 1; end
            3'd5: begin a = 10; useb = 0; inv = 1; end
            default: begin a = 28; b = 31; end
        endcase
    endtask

    task automatic model_reset();
        m_hist = {};
        for (int i = 0; i < 31; i++) m_hist.push_back(1'b0);
        m_link = 0; m_good = 0; m_badrun = 0; m_words = 0; m_errs = 0;
    endtask

    // One clock edge of the behavioural model.
    task automatic model_edge(input logic v, input logic [DW-1:0] d, input logic c);
        int a, b; bit useb, inv, bad, pred, rb;
        bad = 0;
        if (v) begin
            taps(pat_sel, a, b, useb, inv);
            for (int i = 0; i < DW; i++) begin
                rb = d[DW-1-i];
                pred = m_hist[31-a] ^ (useb ? m_hist[31-b] : 1'b0) ^ inv;
                if (pred != rb) bad = 1;
                m_hist.push_back(m_link ? pred : rb);
                void'(m_hist.pop_front());
            end
            if (!m_link) begin
                if (!bad) begin m_good++; if (m_good == 5) begin m_link = 1; m_good = 0; end end
                else m_good = 0;
            end else begin
                if (bad) begin m_badrun++; if (m_badrun == 5) begin m_link = 0; m_badrun = 0; end end
                else m_badrun = 0;
            end
        end
        if (c) begin
            m_words = 0; m_errs = 0;
        end else if (v) begin
            if (m_words < CAP) m_words++;
            if (bad && m_errs < CAP) m_errs++;
        end
    endtask

    // Drive one cycle, update the model, compare all outputs.
    task automatic step(input logic v, input logic [DW-1:0] d, input logic c);
        rx_valid = v; rx_data = d; stat_clr = c;
        @(posedge clk);
        model_edge(v, d, c);
        @(negedge clk);
        chk("R4", "link_up", longint'(link_up), longint'(m_link));
        chk("R2", "word_count", longint'(word_count), m_words);
        chk("R3", "error_count", longint'(error_count), m_errs);
    endtask

    task automatic gen_seed();
        g_hist = {};
        for (int i = 0; i < 30; i++) g_hist.push_back(1'($urandom));
        g_hist.push_back(1'b1);
    endtask

    task automatic gen_word(output logic [DW-1:0] w);
        int a, b; bit useb, inv, nb;
        taps(pat_sel, a, b, useb, inv);
        for (int i = 0; i < DW; i++) begin
            nb = g_hist[31-a] ^ (useb ? g_hist[31-b] : 1'b0) ^ inv;
            w[DW-1-i] = nb;
            g_hist.push_back(nb);
            void'(g_hist.pop_front());
        end
    endtask

    task automatic send_good(input int n);
        logic [DW-1:0] w;
        for (int k = 0; k < n; k++) begin gen_word(w); step(1'b1, w, 1'b0); end
    endtask

    task automatic send_inv(input int n);
        logic [DW-1:0] w;
        for (int k = 0; k < n; k++) begin gen_word(w); step(1'b1, ~w, 1'b0); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        logic [DW-1:0] w;
        longint e0, w0;
        bit l0;
        model_reset();
        gen_seed();
        repeat (3) @(negedge clk);
        chk("R1", "link_up in reset", longint'(link_up), 0);
        chk("R1", "word_count in reset", longint'(word_count), 0);
        chk("R1", "error_count in reset", longint'(error_count), 0);
        rst_n = 1'b1;

        // lock on 7-bit sequence (R6)
        pat_sel = 3'd0;
        send_good(10);
        chk("R6", "locked on code 0", longint'(link_up), 1);

        // R5: four bad, one good, four bad keeps link; fifth bad drops it
        send_inv(4);
        chk("R5", "link after 4 bad", longint'(link_up), 1);
        send_good(1);
        send_inv(4);
        chk("R5", "link after restarted run", longint'(link_up), 1);
        send_inv(1);
        chk("R5", "link after 5 bad", longint'(link_up), 0);

        // R4: history stayed in phase, so good words count at once
        send_good(4);
        chk("R4", "link after 4 good", longint'(link_up), 0);
        send_good(1);
        chk("R4", "link after 5 good", longint'(link_up), 1);

        // R4: a bad word while down restarts the good run
        send_inv(5);
        send_good(3);
        send_inv(1);
        send_good(4);
        chk("R4", "link after interrupted run", longint'(link_up), 0);
        send_good(6);
        chk("R4", "link after fresh run", longint'(link_up), 1);

        // R7: one flipped bit while up costs one error word
        e0 = longint'(error_count);
        gen_word(w);
        step(1'b1, w ^ DW'(16'h0100), 1'b0);
        send_good(3);
        chk("R7", "error delta for one flip", longint'(error_count) - e0, 1);
        chk("R7", "link held", longint'(link_up), 1);

        // R3: fully inverted word counts once
        e0 = longint'(error_count);
        send_inv(1);
        chk("R3", "error delta for multi-bit word", longint'(error_count) - e0, 1);
        send_good(2);

        // R2: idle cycles with garbage change nothing
        e0 = longint'(error_count); w0 = longint'(word_count); l0 = link_up;
        for (int k = 0; k < 6; k++) step(1'b0, DW'($urandom), 1'b0);
        chk("R2", "words over idle", longint'(word_count), w0);
        chk("R2", "errors over idle", longint'(error_count), e0);
        chk("R2", "link over idle", longint'(link_up), longint'(l0));
        send_good(1);
        chk("R2", "history untouched by idle", longint'(error_count), e0);

        // R6/R8: each code, random phase, relock and stay clean
        for (int c = 1; c < 8; c++) begin
            if (c == 6) continue;
            pat_sel = 3'(c);
            gen_seed();
            send_good(16);
            chk("R6", $sformatf("relock code %0d", c), longint'(link_up), 1);
            e0 = longint'(error_count);
            send_good(4);
            chk("R8", $sformatf("clean stream code %0d", c), longint'(error_count), e0);
        end

        // R9: clear beats a valid word, link unchanged
        gen_word(w);
        step(1'b1, w, 1'b1);
        chk("R9", "words after clear", longint'(word_count), 0);
        chk("R9", "errors after clear", longint'(error_count), 0);
        chk("R9", "link after clear", longint'(link_up), 1);

        // mixed random traffic on the 31-bit sequence
        pat_sel = 3'd3;
        gen_seed();
        for (int k = 0; k < 3000; k++) begin
            int r;
            r = int'($urandom_range(0, 199));
            if (r < 50) step(1'b0, DW'($urandom), (r == 0));
            else begin
                gen_word(w);
                if (r < 56) w = w ^ (DW'(1) << $urandom_range(0, DW-1));
                else if (r < 58) w = ~w;
                step(1'b1, w, (r == 199));
            end
        end

        // R10: saturation of both counters
        step(1'b0, '0, 1'b1);
        send_good(1030);
        chk("R10", "word_count saturated", longint'(word_count), CAP);
        send_inv(1030);
        chk("R10", "error_count saturated", longint'(error_count), CAP);
        chk("R10", "word_count held", longint'(word_count), CAP);

        report();
    end

endmodule